// File: doc/BRIEF.md
# Single-Bank Write Sequencer with Self-Closing Row

This block sits on the controller side of a DDR2 memory interface. It carries out one complete write transaction to one bank: it opens the row, writes a burst of four beats with byte masks, and lets the row close by itself. It never sends a separate PRECHARGE command. A client offers a request with a ready/valid handshake. The request holds a bank, a row, a column, four data words and four byte-mask groups. The block then produces the command/address stream and the strobe and data stream for the memory devices.

The row is opened with ACTIVATE. After the row-to-column delay the block issues WRITE with the auto-precharge address bit set. At the write latency the strobe preamble, the two-cycle burst and the postamble follow. The device closes the row internally once write recovery (and the minimum row-active time) are satisfied. The block refuses new work until the precharge period after that point has also run out.

All delays are whole clock cycles and are set by parameters. Double-rate data is modelled as one word in the first half of a cycle (`dqRise`) and one in the second half (`dqFall`). The PHY is responsible for the physical strobe phase.

Top module: `wr_autopre_seq`

## Requirements
- R1: During and right after reset, `reqReady` is 1, `cmdOut` is NOP, and `dqsOe` and `dqOe` are 0.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both 1. ACTIVATE with the request's bank on `bankOut` and its row on `addrOut` appears in the next cycle (cycle 0). `reqReady` is 0 from cycle 0 on.
- R3: WRITE appears in cycle T_RCD to the same bank. `addrOut` carries the column in its low bits, bit 10 is 1 (auto precharge), and all other bits are 0.
- R4: `cmdOut` = {RAS#, CAS#, WE#}, with NOP = 111, ACTIVATE = 011 and WRITE = 100. Every cycle that carries neither ACTIVATE nor WRITE carries NOP.
- R5: In cycle T_RCD+WL-1 (the preamble) `dqsOe` is 1 and `dqsPulse` is 0.
- R6: In cycles T_RCD+WL and T_RCD+WL+1, `dqsOe`, `dqsPulse` and `dqOe` are 1. Beats 0 and 1 appear on `dqRise`/`dqFall` in the first of these cycles, and beats 2 and 3 in the second. Masks follow the same scheme on `dmRise`/`dmFall`.
- R7: Let c be column bits [1:0]. Beat i carries request word (c+i) mod 4 when INTERLEAVE = 0, and word c XOR i when INTERLEAVE = 1. Word k sits at `reqData[k*DQ_W +: DQ_W]` and `reqMask[k*DQ_W/8 +: DQ_W/8]`.
- R8: In cycle T_RCD+WL+2 (the postamble) `dqsOe` is 1 and `dqsPulse` is 0. In all other cycles `dqsOe`, `dqsPulse` and `dqOe` are 0, and the data and mask outputs are 0 whenever `dqOe` is 0.
- R9: `reqReady` returns to 1 in cycle G-1, where G = max(T_RCD+WL+2+WR_CYC, T_RAS) + T_RP. When `reqValid` is held, the next ACTIVATE therefore falls exactly G cycles after the previous one, and never earlier.
- R10: When T_RAS exceeds T_RCD+WL+2+WR_CYC, the row-active minimum alone sets the precharge point in R9, so the spacing grows with T_RAS.
- R11: A request offered while `reqReady` is 0 has no effect. No command is issued, and the burst in progress still carries the data, mask, bank and column of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can take a request |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Row to open |
| reqCol | input | COL_W | Start column (at most 10 bits) |
| reqData | input | 4*DQ_W | Four data words, word k at k*DQ_W |
| reqMask | input | 4*DQ_W/8 | Four byte-mask groups, 1 = byte masked |
| cmdOut | output | 3 | {RAS#, CAS#, WE#} command code |
| bankOut | output | BANK_W | Bank address |
| addrOut | output | max(ROW_W,11) | Row or column address, bit 10 = auto precharge |
| dqsOe | output | 1 | Strobe driven |
| dqsPulse | output | 1 | Strobe toggles this cycle (high first half, low second) |
| dqOe | output | 1 | Data driven |
| dqRise | output | DQ_W | Data word for the first half-cycle |
| dqFall | output | DQ_W | Data word for the second half-cycle |
| dmRise | output | DQ_W/8 | Mask for the first half-cycle |
| dmFall | output | DQ_W/8 | Mask for the second half-cycle |

## Verification
Two events can fall in the same cycle: `reqReady` coming back at the end of the recovery-plus-precharge window, and the acceptance of the next request. The bench provokes this by offering each next request in the very cycle that `reqReady` rises. It judges the result by requiring ACTIVATE exactly G cycles after the previous one and NOP in every cycle between, once with G set by write recovery and once with a longer row-active minimum. A stray request presented while the window is closed is checked against the outputs of the burst already under way.

// File: rtl/wr_autopre_pkg.sv
package wr_autopre_pkg;

  // Command code on {RAS#, CAS#, WE#}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100
  } ddrCmd_e;

  // Strobes from the control to the datapath, one cycle ahead of the pins
  typedef struct packed {
    logic act;      // launch ACTIVATE and capture the request
    logic wr;       // launch WRITE with auto precharge
    logic dqsPre;   // strobe preamble
    logic beat0;    // beats 0 and 1
    logic beat1;    // beats 2 and 3
    logic dqsPost;  // strobe postamble
  } seqStrb_t;

  localparam int BURST_LEN = 4;
  localparam int AP_BIT_POS = 10;

endpackage

// File: rtl/wr_autopre_ctrl.sv
module wr_autopre_ctrl
  import wr_autopre_pkg::*;
#(
  parameter int T_RCD  = 3,
  parameter int WL     = 2,
  parameter int WR_CYC = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output seqStrb_t strb
);

  // Cycle numbers relative to the ACTIVATE cycle (cycle 0)
  localparam int DATA0     = T_RCD + WL;
  localparam int RECOV_END = DATA0 + 2 + WR_CYC;
  localparam int PRE_AT    = (RECOV_END > T_RAS) ? RECOV_END : T_RAS;
  localparam int GAP       = PRE_AT + T_RP;
  localparam int CNT_W     = $clog2(GAP + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             lastCyc;

  assign reqReady = !busy;
  assign accept   = reqValid && !busy;
  assign lastCyc  = busy && (cnt == CNT_W'(GAP - 2));

  // Each strobe fires one cycle before the pin cycle it names
  always_comb begin
    strb         = '0;
    strb.act     = accept;
    strb.wr      = busy && (cnt == CNT_W'(T_RCD - 1));
    strb.dqsPre  = busy && (cnt == CNT_W'(DATA0 - 2));
    strb.beat0   = busy && (cnt == CNT_W'(DATA0 - 1));
    strb.beat1   = busy && (cnt == CNT_W'(DATA0));
    strb.dqsPost = busy && (cnt == CNT_W'(DATA0 + 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (lastCyc) busy <= 1'b0;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= CNT_W'(GAP - 2)));  // R9

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.act, strb.wr, strb.beat0, strb.beat1, strb.dqsPost}));  // R4

  AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);  // R2

endmodule

// File: rtl/wr_autopre_dpath.sv
module wr_autopre_dpath
  import wr_autopre_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 14,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 16,
  parameter int INTERLEAVE = 0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrb_t                       strb,
  input  logic [BANK_W-1:0]              reqBank,
  input  logic [ROW_W-1:0]               reqRow,
  input  logic [COL_W-1:0]               reqCol,
  input  logic [BURST_LEN*DQ_W-1:0]      reqData,
  input  logic [BURST_LEN*(DQ_W/8)-1:0]  reqMask,
  output logic [2:0]                     cmdOut,
  output logic [BANK_W-1:0]              bankOut,
  output logic [(ROW_W>11?ROW_W:11)-1:0] addrOut,
  output logic                           dqsOe,
  output logic                           dqsPulse,
  output logic                           dqOe,
  output logic [DQ_W-1:0]                dqRise,
  output logic [DQ_W-1:0]                dqFall,
  output logic [DQ_W/8-1:0]              dmRise,
  output logic [DQ_W/8-1:0]              dmFall
);

  localparam int DM_W   = DQ_W / 8;
  localparam int ADDR_W = (ROW_W > 11) ? ROW_W : 11;
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1 << AP_BIT_POS);

  logic [BANK_W-1:0]             holdBank;
  logic [COL_W-1:0]              holdCol;
  logic [BURST_LEN*DQ_W-1:0]     holdData;
  logic [BURST_LEN*DM_W-1:0]     holdMask;

  logic [DQ_W-1:0] beatDq [BURST_LEN];
  logic [DM_W-1:0] beatDm [BURST_LEN];

  // Request capture at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdBank <= '0;
      holdCol  <= '0;
      holdData <= '0;
      holdMask <= '0;
    end else if (strb.act) begin
      holdBank <= reqBank;
      holdCol  <= reqCol;
      holdData <= reqData;
      holdMask <= reqMask;
    end
  end

  // Burst order: beat i picks a word by the start column's low two bits
  for (genvar i = 0; i < BURST_LEN; i++) begin : gBeat
    logic [1:0] idx;
    if (INTERLEAVE != 0) begin : gIlv
      assign idx = holdCol[1:0] ^ 2'(i);
    end else begin : gSeq
      assign idx = holdCol[1:0] + 2'(i);
    end
    assign beatDq[i] = holdData[idx*DQ_W +: DQ_W];
    assign beatDm[i] = holdMask[idx*DM_W +: DM_W];
  end

  // Command and address pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOut  <= CMD_NOP;
      bankOut <= '0;
      addrOut <= '0;
    end else if (strb.act) begin
      cmdOut  <= CMD_ACT;
      bankOut <= reqBank;
      addrOut <= ADDR_W'(reqRow);
    end else if (strb.wr) begin
      cmdOut  <= CMD_WR;
      bankOut <= holdBank;
      addrOut <= ADDR_W'(holdCol) | AP_MASK;
    end else begin
      cmdOut  <= CMD_NOP;
      bankOut <= '0;
      addrOut <= '0;
    end
  end

  // Strobe, data and mask pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqsOe    <= 1'b0;
      dqsPulse <= 1'b0;
      dqOe     <= 1'b0;
      dqRise   <= '0;
      dqFall   <= '0;
      dmRise   <= '0;
      dmFall   <= '0;
    end else begin
      dqsOe    <= strb.dqsPre | strb.beat0 | strb.beat1 | strb.dqsPost;
      dqsPulse <= strb.beat0 | strb.beat1;
      dqOe     <= strb.beat0 | strb.beat1;
      if (strb.beat0) begin
        dqRise <= beatDq[0];
        dqFall <= beatDq[1];
        dmRise <= beatDm[0];
        dmFall <= beatDm[1];
      end else if (strb.beat1) begin
        dqRise <= beatDq[2];
        dqFall <= beatDq[3];
        dmRise <= beatDm[2];
        dmFall <= beatDm[3];
      end else begin
        dqRise <= '0;
        dqFall <= '0;
        dmRise <= '0;
        dmFall <= '0;
      end
    end
  end

  AST_BURST_FOLLOWS_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe && !dqsPulse && !$past(dqsOe)) |=> dqsPulse);  // R5

  AST_POST_AFTER_BURST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> (dqsOe && !dqsPulse));  // R8

  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqRise == '0 && dqFall == '0 && dmRise == '0 && dmFall == '0));  // R8

endmodule

// File: rtl/wr_autopre_seq.sv
module wr_autopre_seq
  import wr_autopre_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 14,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 16,
  parameter int T_RCD      = 3,
  parameter int WL         = 2,
  parameter int WR_CYC     = 3,
  parameter int T_RP       = 3,
  parameter int T_RAS      = 8,
  parameter int INTERLEAVE = 0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  output logic                           reqReady,
  input  logic [BANK_W-1:0]              reqBank,
  input  logic [ROW_W-1:0]               reqRow,
  input  logic [COL_W-1:0]               reqCol,
  input  logic [4*DQ_W-1:0]              reqData,
  input  logic [4*(DQ_W/8)-1:0]          reqMask,
  output logic [2:0]                     cmdOut,
  output logic [BANK_W-1:0]              bankOut,
  output logic [(ROW_W>11?ROW_W:11)-1:0] addrOut,
  output logic                           dqsOe,
  output logic                           dqsPulse,
  output logic                           dqOe,
  output logic [DQ_W-1:0]                dqRise,
  output logic [DQ_W-1:0]                dqFall,
  output logic [DQ_W/8-1:0]              dmRise,
  output logic [DQ_W/8-1:0]              dmFall
);

  localparam int RECOV_END = T_RCD + WL + 2 + WR_CYC;
  localparam int GAP       = ((RECOV_END > T_RAS) ? RECOV_END : T_RAS) + T_RP;
  localparam int GAP_W     = $clog2(GAP + 2);

  // Write-recovery count must fit the 3-bit mode-register field (2..8)
  if (WR_CYC < 2 || WR_CYC > 8) begin : gBadWr
    $error("WR_CYC outside the encodable range 2..8");
  end
  if (COL_W > AP_BIT_POS || COL_W < 2) begin : gBadCol
    $error("COL_W must lie in 2..10");
  end

  seqStrb_t strb;

  wr_autopre_ctrl #(
    .T_RCD (T_RCD),
    .WL    (WL),
    .WR_CYC(WR_CYC),
    .T_RP  (T_RP),
    .T_RAS (T_RAS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strb    (strb)
  );

  wr_autopre_dpath #(
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .DQ_W      (DQ_W),
    .INTERLEAVE(INTERLEAVE)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqBank (reqBank),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .reqData (reqData),
    .reqMask (reqMask),
    .cmdOut  (cmdOut),
    .bankOut (bankOut),
    .addrOut (addrOut),
    .dqsOe   (dqsOe),
    .dqsPulse(dqsPulse),
    .dqOe    (dqOe),
    .dqRise  (dqRise),
    .dqFall  (dqFall),
    .dmRise  (dmRise),
    .dmFall  (dmFall)
  );

  // Pin-level history for the timing checks below
  logic [BANK_W-1:0] lastActBank;
  logic [GAP_W-1:0]  sinceAct;
  logic              seenAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastActBank <= '0;
      sinceAct    <= '0;
      seenAct     <= 1'b0;
    end else if (cmdOut == CMD_ACT) begin
      lastActBank <= bankOut;
      sinceAct    <= GAP_W'(1);
      seenAct     <= 1'b1;
    end else if (sinceAct < GAP_W'(GAP)) begin
      sinceAct <= sinceAct + 1'b1;
    end
  end

  AST_ACT_FROM_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_ACT) |-> $past(reqValid && reqReady));  // R2

  AST_WR_SAME_BANK_AP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_WR) |-> (bankOut == lastActBank && addrOut[AP_BIT_POS]));  // R3

  AST_WR_AFTER_RCD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_WR) |-> (seenAct && sinceAct == GAP_W'(T_RCD)));  // R3

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_ACT && seenAct) |-> (sinceAct >= GAP_W'(GAP)));  // R9

  AST_DATA_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (dqsOe && dqsPulse));  // R6

  AST_BUSY_DURING_BURST: assert property (@(posedge clk) disable iff (!rstN)
    dqsOe |-> !reqReady);  // R11

  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_NOP || cmdOut == CMD_ACT || cmdOut == CMD_WR));  // R4

endmodule

// File: tb/wr_autopre_seq_tb.sv
module wr_autopre_seq_tb;

  localparam int RCD   = 3;
  localparam int WLAT  = 2;
  localparam int WRC   = 3;
  localparam int TRP   = 3;
  localparam int RAS_A = 8;
  localparam int RAS_B = 14;

  function automatic int gapOf(int ras);
    int rec = RCD + WLAT + 2 + WRC;
    return ((rec > ras) ? rec : ras) + TRP;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        validA = 1'b0, validB = 1'b0;
  logic [2:0]  bankIn = '0;
  logic [13:0] rowIn = '0;
  logic [9:0]  colIn = '0;
  logic [63:0] dataIn = '0;
  logic [7:0]  maskIn = '0;

  logic readyA, dqsOeA, dqsPA, dqOeA, readyB, dqsOeB, dqsPB, dqOeB;
  logic [2:0] cmdA, cmdB, bankA, bankB;
  logic [13:0] addrA, addrB;
  logic [15:0] dqRA, dqFA, dqRB, dqFB;
  logic [1:0] dmRA, dmFA, dmRB, dmFB;

  wr_autopre_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(validA), .reqReady(readyA),
    .reqBank(bankIn), .reqRow(rowIn), .reqCol(colIn), .reqData(dataIn), .reqMask(maskIn),
    .cmdOut(cmdA), .bankOut(bankA), .addrOut(addrA), .dqsOe(dqsOeA), .dqsPulse(dqsPA),
    .dqOe(dqOeA), .dqRise(dqRA), .dqFall(dqFA), .dmRise(dmRA), .dmFall(dmFA));

  wr_autopre_seq #(.T_RAS(RAS_B), .INTERLEAVE(1)) u_dutB (
    .clk(clk), .rstN(rstN), .reqValid(validB), .reqReady(readyB),
    .reqBank(bankIn), .reqRow(rowIn), .reqCol(colIn), .reqData(dataIn), .reqMask(maskIn),
    .cmdOut(cmdB), .bankOut(bankB), .addrOut(addrB), .dqsOe(dqsOeB), .dqsPulse(dqsPB),
    .dqOe(dqOeB), .dqRise(dqRB), .dqFall(dqFB), .dmRise(dmRB), .dmFall(dmFB));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int ord(int c, int i, bit ilv);
    return ilv ? (c ^ i) : ((c + i) % 4);
  endfunction

  // Start at a negedge with the selected unit ready; end at the negedge of its last cycle.
  task automatic doTxn(bit useB, logic [2:0] b, logic [13:0] r, logic [9:0] c,
                       logic [63:0] d, logic [7:0] m, bit junk);
    int gap = useB ? gapOf(RAS_B) : gapOf(RAS_A);
    int d0 = RCD + WLAT;
    int cl = int'(c[1:0]);
    logic [2:0] expCmd;
    logic [15:0] eR, eF;
    logic [1:0] mR, mF;
    chk("R9 ready before offer", useB ? readyB : readyA, 1);
    bankIn = b; rowIn = r; colIn = c; dataIn = d; maskIn = m;
    if (useB) validB = 1'b1; else validA = 1'b1;
    @(negedge clk);
    validA = 1'b0; validB = 1'b0;
    for (int k = 0; k < gap; k++) begin
      if (k > 0) @(negedge clk);
      if (junk && k == 1) begin
        bankIn = ~b; rowIn = ~r; colIn = ~c; dataIn = ~d; maskIn = ~m;
        if (useB) validB = 1'b1; else validA = 1'b1;
      end
      if (junk && k == gap - 2) begin
        validA = 1'b0; validB = 1'b0;
      end
      expCmd = (k == 0) ? 3'b011 : (k == RCD) ? 3'b100 : 3'b111;
      chk($sformatf("R4 R10 R11 cmd k=%0d", k), useB ? cmdB : cmdA, expCmd);
      if (k == 0) begin
        chk("R2 act bank", useB ? bankB : bankA, b);
        chk("R2 act row", useB ? addrB : addrA, r);
      end
      if (k == RCD) begin
        chk("R3 wr bank", useB ? bankB : bankA, b);
        chk("R3 wr addr with bit10", useB ? addrB : addrA, 14'(c) | 14'h0400);
      end
      chk($sformatf("R5 R6 R8 dqsOe k=%0d", k), useB ? dqsOeB : dqsOeA,
          (k >= d0 - 1 && k <= d0 + 2));
      chk($sformatf("R5 R6 R8 dqsPulse k=%0d", k), useB ? dqsPB : dqsPA,
          (k == d0 || k == d0 + 1));
      chk($sformatf("R6 R8 dqOe k=%0d", k), useB ? dqOeB : dqOeA,
          (k == d0 || k == d0 + 1));
      eR = '0; eF = '0; mR = '0; mF = '0;
      if (k == d0 || k == d0 + 1) begin
        int base = (k == d0) ? 0 : 2;
        eR = d[ord(cl, base, useB)*16 +: 16];
        eF = d[ord(cl, base + 1, useB)*16 +: 16];
        mR = m[ord(cl, base, useB)*2 +: 2];
        mF = m[ord(cl, base + 1, useB)*2 +: 2];
      end
      chk($sformatf("R7 R11 dqRise k=%0d", k), useB ? dqRB : dqRA, eR);
      chk($sformatf("R7 R11 dqFall k=%0d", k), useB ? dqFB : dqFA, eF);
      chk($sformatf("R6 R7 dmRise k=%0d", k), useB ? dmRB : dmRA, mR);
      chk($sformatf("R6 R7 dmFall k=%0d", k), useB ? dmFB : dmFA, mF);
      chk($sformatf("R2 R9 ready k=%0d", k), useB ? readyB : readyA, (k >= gap - 1));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready A", readyA, 1);
    chk("R1 cmd A", cmdA, 3'b111);
    chk("R1 dqsOe A", dqsOeA, 0);
    chk("R1 dqOe A", dqOeA, 0);
    chk("R1 ready B", readyB, 1);
    chk("R1 cmd B", cmdB, 3'b111);
    chk("R1 dqsOe B", dqsOeB, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 idle NOP", cmdA, 3'b111);
    end
    // Sequential order, recovery-limited spacing, back-to-back offers
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 4; k++)
        d[k*16 +: 16] = 16'(16'hA000 + i * 16'h0100 + k * 16'h0011);
      doTxn(1'b0, 3'(i), 14'(i * 977 + 5), {8'(i * 13 + 5), 2'(i)}, d, 8'(i * 29 + 7), i >= 4);
    end
    // Interleaved order, row-active-limited spacing (R10)
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++)
        d[k*16 +: 16] = 16'(16'h5000 + i * 16'h0200 + k * 16'h0033);
      doTxn(1'b1, 3'(7 - i), 14'(i * 1511 + 9), {8'(i * 7 + 3), 2'(3 - i)}, d, 8'(i * 53 + 1), i == 2);
    end
    repeat (2) @(negedge clk);
    chk("R4 trailing NOP A", cmdA, 3'b111);
    chk("R4 trailing NOP B", cmdB, 3'b111);
    summary();
  end

endmodule